// File: doc/BRIEF.md
# Memory Write Protection Unit

This unit decides, cycle by cycle, whether a byte headed for the memory array and a write to the status register may take effect. An upstream serial front end decodes the opcodes and hands this unit simple pulses: set the write-enable latch, load a burst start address, commit one data byte, write the status register. The unit holds the write-enable latch, the protect-enable bit and the two block-protect bits. It runs the burst address cursor and gives one registered permission pulse per committed byte, together with the address that byte belongs to.

The active-low protect pin only gates status register writes, and only while the protect-enable bit is set. The pin is sampled on every cycle in which chip select is high and is then held for the whole transaction. A burst that enters a protected region keeps its address advancing but raises no write permission. Once the address wraps into an unprotected region, writing resumes.

Top module: `wp_guard`

## Requirements
- R1: On reset, `wel_o`, `wpen_o`, `bp_o`, `mem_we` and `sr_we` are all 0.
- R2: While `wel_o` is 0, no `byte_valid` produces `mem_we` and no `sr_wr` produces `sr_we` or changes `wpen_o`/`bp_o`.
- R3: Block-protect code `bp_o` selects the locked range: 00 none, 01 the top quarter of the address space (0x6000–0x7FFF at the default width), 10 the top half (0x4000–0x7FFF), 11 every address. A byte at a locked address never produces `mem_we`.
- R4: With `wel_o`=1 and `wpen_o`=0, a status write is accepted whatever the pin level.
- R5: With `wel_o`=1, `wpen_o`=1 and the captured pin low, a status write is refused and leaves `wpen_o` and `bp_o` unchanged. Bytes to unlocked addresses are still written.
- R6: With `wel_o`=1, `wpen_o`=1 and the captured pin high, a status write is accepted.
- R7: The pin level used is the one sampled at the last clock edge that saw `cs_n` high. Pin changes while `cs_n` stays low have no effect on that transaction.
- R8: A byte pulse that comes with `burst_start` uses `burst_addr`. Each later byte uses the previous address plus one, wrapping from the top address to 0. `mem_addr` reports the address, and permission is judged on that address, so a burst skips locked addresses and resumes after the wrap.
- R9: `mem_we` rises for exactly one cycle, one clock after each permitted `byte_valid`, and is 0 after a cycle without `byte_valid`.
- R10: `wel_set` sets `wel_o` at the next edge. At the first edge with `cs_n` high after a transaction that held a `burst_start` or an `sr_wr`, `wel_o` clears, whether or not the writes were accepted.
- R11: An accepted status write gives `sr_we` for one cycle, one clock after `sr_wr`, and at that edge loads `wpen_o` from `sr_wdata[7]` and `bp_o` from `sr_wdata[3:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, low during a transaction |
| wp_n | input | 1 | Protect pin, low requests protection |
| wel_set | input | 1 | Pulse: set the write-enable latch |
| burst_start | input | 1 | Pulse: load burst start address |
| burst_addr | input | ADDR_W | Burst start address |
| byte_valid | input | 1 | Pulse: commit one data byte |
| sr_wr | input | 1 | Pulse: status register write |
| sr_wdata | input | 8 | Status write data |
| mem_we | output | 1 | Registered byte write permission |
| mem_addr | output | ADDR_W | Address of the permitted byte |
| sr_we | output | 1 | Registered status write permission |
| wel_o | output | 1 | Write-enable latch |
| wpen_o | output | 1 | Protect-enable bit |
| bp_o | output | 2 | Block-protect code |

## Verification
Two events can meet in neighbouring cycles. The first is a burst crossing the top of the array, where a locked byte at the last address is followed at once by a writable byte at address 0. The bench provokes this by starting bursts just below the wrap and judges every byte against a bench function of the address and protect code. The second is a pin edge that lands on the same edge as chip select dropping. It is driven together with the select change, and the bench expects the level captured one edge earlier.

// File: rtl/wp_pkg.sv
// Package: shared encodings for the write protection unit.
// Assumes the block-protect code is two bits wide.
package wp_pkg;

    typedef enum logic [1:0] {
        GUARD_NONE    = 2'b00,
        GUARD_QUARTER = 2'b01,
        GUARD_HALF    = 2'b10,
        GUARD_ALL     = 2'b11
    } guard_t;

    // Bit positions of fields inside the status write data byte.
    localparam int SR_WPEN_BIT = 7;
    localparam int SR_BP_HI    = 3;
    localparam int SR_BP_LO    = 2;

    // True when an address with top bits hi2 falls in the locked range.
    function automatic logic guard_hit(input logic [1:0] hi2, input guard_t code);
        logic hit;
        unique case (code)
            GUARD_NONE:    hit = 1'b0;
            GUARD_QUARTER: hit = hi2 == 2'b11;
            GUARD_HALF:    hit = hi2[1];
            default:       hit = 1'b1;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/wp_region.sv
// Module: wp_region
// Combinational decode of whether an address lies in the locked range.
// Assumes ADDR_W >= 2. Only the two top address bits matter.
module wp_region #(
    parameter int ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  wp_pkg::guard_t    code,
    output logic              locked
);
    localparam int TOP = ADDR_W - 1;

    // Decode the locked range from the top two address bits.
    always_comb begin
        locked = wp_pkg::guard_hit(addr[TOP -: 2], code);
    end
endmodule

// File: rtl/wp_cursor.sv
// Module: wp_cursor
// Burst address cursor and registered per-byte write permission.
// Assumes the front end pulses byte_valid once per byte. The address wraps
// naturally at 2**ADDR_W, and locked addresses still advance the cursor.
module wp_cursor #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  logic [ADDR_W-1:0] burst_addr,
    input  logic              byte_valid,
    input  logic              wel,
    input  wp_pkg::guard_t    code,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr
);
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] use_addr;
    logic              locked;

    // Pick the address the current byte belongs to.
    always_comb begin
        use_addr = burst_start ? burst_addr : cur_q;
    end

    wp_region #(.ADDR_W(ADDR_W)) region_i (
        .addr   (use_addr),
        .code   (code),
        .locked (locked)
    );

    // Advance the cursor and register one permission pulse per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= '0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
        end else begin
            mem_we <= byte_valid && wel && !locked;
            if (byte_valid) begin
                mem_addr <= use_addr;
                cur_q    <= use_addr + 1'b1;
            end else if (burst_start) begin
                cur_q <= burst_addr;
            end
        end
    end
endmodule

// File: rtl/wp_state.sv
// Module: wp_state
// Holds the write-enable latch, protect-enable bit, block-protect code and
// the pin level frozen for the transaction, and grants status writes.
// Assumes cs_n high between transactions for at least one clock.
module wp_state (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           wp_n,
    input  logic           wel_set,
    input  logic           burst_start,
    input  logic           sr_wr,
    input  logic [7:0]     sr_wdata,
    output logic           sr_we,
    output logic           wel,
    output logic           wpen,
    output wp_pkg::guard_t code,
    output logic           pin_frz
);
    logic wrote_q;
    logic sr_ok;

    // Status write is allowed unless the latch is clear or the pin locks it.
    always_comb begin
        sr_ok = wel && !(wpen && !pin_frz);
    end

    // Track the pin while deselected; hold it through a transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)    pin_frz <= 1'b1;
        else if (cs_n) pin_frz <= wp_n;
    end

    // Write-enable latch: set on request, clear after a write transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel     <= 1'b0;
            wrote_q <= 1'b0;
        end else begin
            if (cs_n && wrote_q) begin
                wel     <= 1'b0;
                wrote_q <= 1'b0;
            end else if (!cs_n && (burst_start || sr_wr)) begin
                wrote_q <= 1'b1;
            end
            if (wel_set) wel <= 1'b1;
        end
    end

    // Status register fields and the registered grant pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wpen  <= 1'b0;
            code  <= wp_pkg::GUARD_NONE;
            sr_we <= 1'b0;
        end else begin
            sr_we <= sr_wr && sr_ok;
            if (sr_wr && sr_ok) begin
                wpen <= sr_wdata[wp_pkg::SR_WPEN_BIT];
                code <= wp_pkg::guard_t'(sr_wdata[wp_pkg::SR_BP_HI:wp_pkg::SR_BP_LO]);
            end
        end
    end
endmodule

// File: rtl/wp_guard.sv
// Module: wp_guard (top)
// Write protection unit: status register state plus burst cursor.
// Assumes the front end never raises wel_set while a write transaction
// is being closed. SPI shifting and nonvolatile storage lie outside.
module wp_guard #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              wel_set,
    input  logic              burst_start,
    input  logic [ADDR_W-1:0] burst_addr,
    input  logic              byte_valid,
    input  logic              sr_wr,
    input  logic [7:0]        sr_wdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              sr_we,
    output logic              wel_o,
    output logic              wpen_o,
    output logic [1:0]        bp_o
);
    wp_pkg::guard_t code;
    logic           pin_frz;

    wp_state state_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .wp_n        (wp_n),
        .wel_set     (wel_set),
        .burst_start (burst_start),
        .sr_wr       (sr_wr),
        .sr_wdata    (sr_wdata),
        .sr_we       (sr_we),
        .wel         (wel_o),
        .wpen        (wpen_o),
        .code        (code),
        .pin_frz     (pin_frz)
    );

    wp_cursor #(.ADDR_W(ADDR_W)) cursor_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_start (burst_start),
        .burst_addr  (burst_addr),
        .byte_valid  (byte_valid),
        .wel         (wel_o),
        .code        (code),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr)
    );

    // Expose the block-protect code as plain bits.
    always_comb begin
        bp_o = code;
    end
endmodule

// File: rtl/wp_guard_chk.sv
// Module: wp_guard_chk
// Temporal checks on the write protection unit, attached by bind.
module wp_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       byte_valid,
    input logic       sr_wr,
    input logic       mem_we,
    input logic       sr_we,
    input logic       wel_o,
    input logic       wpen_o,
    input logic [1:0] bp_o,
    input logic       pin_frz
);
    p_latch_gates_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !wel_o) |=> !mem_we);

    p_latch_gates_sr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && !wel_o) |=> (!sr_we && $stable(bp_o) && $stable(wpen_o)));

    p_full_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && bp_o == 2'b11) |=> !mem_we);

    p_pin_blocks_sr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && wpen_o && !pin_frz) |=> (!sr_we && $stable(bp_o) && $stable(wpen_o)));

    p_pin_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(pin_frz));

    p_byte_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> !mem_we);

    p_sr_grant_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> $past(sr_wr));
endmodule

bind wp_guard wp_guard_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .byte_valid (byte_valid),
    .sr_wr      (sr_wr),
    .mem_we     (mem_we),
    .sr_we      (sr_we),
    .wel_o      (wel_o),
    .wpen_o     (wpen_o),
    .bp_o       (bp_o),
    .pin_frz    (pin_frz)
);

// File: tb/wp_guard_tb_top.sv
// Bench for wp_guard: directed corner cases plus seeded random traffic,
// compared against a bench-side model of the requirements.
module wp_guard_tb_top;
    localparam int AW   = 15;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wp_n = 1'b1;
    logic          wel_set = 1'b0;
    logic          burst_start = 1'b0;
    logic [AW-1:0] burst_addr = '0;
    logic          byte_valid = 1'b0;
    logic          sr_wr = 1'b0;
    logic [7:0]    sr_wdata = '0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic          sr_we;
    logic          wel_o;
    logic          wpen_o;
    logic [1:0]    bp_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state
    bit       m_wel  = 0;
    bit       m_wpen = 0;
    bit [1:0] m_bp   = 0;

    always #2 clk = ~clk;

    wp_guard #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .wel_set(wel_set), .burst_start(burst_start), .burst_addr(burst_addr),
        .byte_valid(byte_valid), .sr_wr(sr_wr), .sr_wdata(sr_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .sr_we(sr_we),
        .wel_o(wel_o), .wpen_o(wpen_o), .bp_o(bp_o)
    );

    function automatic bit locked(input int a, input bit [1:0] bp);
        case (bp)
            2'b00:   return 0;
            2'b01:   return a >= 'h6000;
            2'b10:   return a >= 'h4000;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        chk(wel_o == m_wel, {req, " wel"}, wel_o, m_wel);
        chk(wpen_o == m_wpen, {req, " wpen"}, wpen_o, m_wpen);
        chk(bp_o == m_bp, {req, " bp"}, bp_o, m_bp);
    endtask

    // R10: set the write-enable latch in its own transaction
    task automatic set_wel();
        cs_n = 0; wel_set = 1;
        tick();
        wel_set = 0; cs_n = 1;
        m_wel = 1;
        chk(wel_o == 1, "R10 set", wel_o, 1);
        tick();
        chk(wel_o == 1, "R10 hold", wel_o, 1);
    endtask

    // status write; pin level at select drop and during transaction
    task automatic sr_write(input bit [7:0] d, input bit pin0, input bit pin1, input string req);
        bit ok;
        cs_n = 1; wp_n = pin0;
        tick();
        cs_n = 0; wp_n = pin1;      // R7: edge coincides with select drop
        tick();
        wp_n = ~pin1;               // R7: toggle again mid-transaction
        sr_wr = 1; sr_wdata = d;
        ok = m_wel && !(m_wpen && !pin0);
        tick();
        sr_wr = 0;
        if (ok) begin
            m_wpen = d[7];
            m_bp   = d[3:2];
        end
        chk(sr_we == ok, {req, " R11 sr_we"}, sr_we, ok);
        check_regs({req, " R11"});
        tick();
        chk(sr_we == 0, "R11 pulse", sr_we, 0);
        cs_n = 1;
        tick();
        m_wel = 0;
        chk(wel_o == 0, "R10 clear after sr", wel_o, 0);
    endtask

    // burst of n bytes from start, random idle gaps between bytes
    task automatic burst(input int start, input int n, input bit gaps, input string req);
        int a = start;
        bit exp;
        cs_n = 1;
        tick();
        cs_n = 0;
        for (int i = 0; i < n; i++) begin
            burst_start = (i == 0);
            burst_addr  = AW'(start);
            byte_valid  = 1;
            tick();
            burst_start = 0; byte_valid = 0;
            exp = m_wel && !locked(a, m_bp);
            chk(mem_we == exp, {req, " R8 mem_we"}, mem_we, exp);
            chk(mem_addr == AW'(a), {req, " R8 addr"}, mem_addr, a);
            a = (a + 1) & MASK;
            if (gaps && ($urandom % 2 == 1)) begin
                tick();
                chk(mem_we == 0, "R9 no byte", mem_we, 0);
            end
        end
        cs_n = 1;
        tick();
        m_wel = 0;
        chk(mem_we == 0, "R9 single pulse", mem_we, 0);
        chk(wel_o == 0, "R10 clear after burst", wel_o, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) tick();
        // R1: reset state
        chk(wel_o == 0 && wpen_o == 0 && bp_o == 0, "R1 regs", {wel_o, wpen_o, bp_o}, 0);
        chk(mem_we == 0 && sr_we == 0, "R1 pulses", {mem_we, sr_we}, 0);
        rst_n = 1;
        tick();

        // R2: latch clear blocks status write and bytes
        sr_write(8'h8C, 1, 1, "R2");
        burst('h0010, 2, 0, "R2");
        // R4: protect-enable off, pin low, status write accepted
        set_wel();
        sr_write(8'h04, 0, 0, "R4");
        // R8 / R3: wrap from locked top quarter into writable bottom
        set_wel();
        burst('h7FFE, 4, 0, "R3 quarter wrap");
        // R6: enable on with pin high accepted
        set_wel();
        sr_write(8'h88, 1, 1, "R6");
        // R5: pin low at select drop refuses and keeps bits
        set_wel();
        sr_write(8'h00, 0, 1, "R5");
        // R7: pin high captured, goes low during transaction -> accepted
        set_wel();
        sr_write(8'h88, 1, 0, "R7");
        // R5: pin low still allows unlocked bytes; half locked
        set_wel();
        wp_n = 0;
        burst('h3FFE, 3, 0, "R5 half");
        // R3: whole array locked
        set_wel();
        sr_write(8'h8C, 1, 1, "R3 set all");
        set_wel();
        burst('h0000, 3, 1, "R3 all");

        // random traffic
        for (int it = 0; it < 150; it++) begin
            if ($urandom % 4 != 0) set_wel();
            if ($urandom % 2 == 0)
                sr_write(8'($urandom), 1'($urandom), 1'($urandom), "rand");
            else begin
                int s;
                s = ($urandom % 2 == 0) ? (MASK - int'($urandom % 4)) : int'($urandom) & MASK;
                burst(s, 1 + int'($urandom % 6), 1, "rand");
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule